// File: doc/BRIEF.md
# Late-Write Synchronous SRAM Front End

This block is a synchronous single-port memory with a small internal array. Its words are split into byte lanes, and it returns read data with a one-cycle flow-through latency. A write command and its address are captured on one enabled clock edge, and the data for that write is taken from the bus on the next enabled edge. Because writes and reads have the same one-cycle offset, reads and writes can be issued on consecutive cycles in any order, and the shared data bus never needs an idle turnaround cycle.

Accesses start from an external address on a load cycle and can continue as bursts of up to four beats. A 2-bit burst counter steps the low address bits. A static mode input selects the beat order: interleaved (XOR) or linear (add, modulo 4). Three further controls act on the block:
- A clock-enable input can freeze all internal state for a cycle.
- Three chip selects deselect the device.
- An asynchronous output enable gates the bus drivers.

The bidirectional bus is modelled as separate data-in, data-out and drive-enable ports.

Top module: `lw_sram`

## Requirements
- R1: While reset is asserted, and after it is released, the device is deselected and `dq_oe_o` is 0, even with `out_en_ni` low.
- R2: An enabled edge is a load when `adv_i`=0. It selects the device only if `sel_a_ni`=0, `sel_b_i`=1 and `sel_c_ni`=0. A selected load with `rd_nwr_i`=1 starts a read of `addr_i`. During the cycle after that edge, `dq_o` shows the stored word, and `dq_oe_o`=1 if `out_en_ni`=0.
- R3: A selected load with `rd_nwr_i`=0 starts a write. The word on `dq_i` at the next enabled edge is stored. Byte lane b (bits b*9+8..b*9) is written only if `byte_wr_ni[b]`=0, as sampled with the command.
- R4: Reads and writes may follow each other on consecutive cycles. A read issued on the edge that takes a write's data, to the same address, returns the new data.
- R5: A load with any chip select inactive is a deselect, and the bus is not driven. Continue cycles after a deselect stay deselected.
- R6: When `adv_i`=1, the address, chip selects and `rd_nwr_i` are ignored. The burst counter advances by one, and the operation keeps the type chosen at the burst start. `byte_wr_ni` is sampled again on every continue write beat.
- R7: With `order_il_i`=1, the low two address bits of beat n are start XOR n.
- R8: With `order_il_i`=0, the low two address bits of beat n are (start + n) mod 4. The upper address bits never change within a burst, and beat 4 returns to the start address.
- R9: A write with both byte enables high changes no memory and leaves the bus undriven.
- R10: With `out_en_ni`=1, a read accesses the array but `dq_oe_o`=0. `out_en_ni` acts on `dq_oe_o` without waiting for a clock edge.
- R11: On an edge with `clk_en_ni`=1, all state is frozen. A read in progress keeps driving the same word. A pending write is not performed; it takes its data on the next enabled edge.
- R12: During a write data cycle, `dq_oe_o`=0 whatever the level of `out_en_ni`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clk_en_ni | input | 1 | Clock enable, active low; high freezes the cycle |
| sel_a_ni | input | 1 | Chip select, active low |
| sel_b_i | input | 1 | Chip select, active high |
| sel_c_ni | input | 1 | Chip select, active low |
| adv_i | input | 1 | 1 = continue burst, 0 = load new command |
| rd_nwr_i | input | 1 | 1 = read, 0 = write (on load cycles) |
| byte_wr_ni | input | NUM_BYTES | Per-lane write enables, active low |
| order_il_i | input | 1 | Static burst order: 1 interleaved, 0 linear |
| out_en_ni | input | 1 | Asynchronous output enable, active low |
| addr_i | input | ADDR_W | Start address for load cycles |
| dq_i | input | BYTE_W*NUM_BYTES | Write data from the bus |
| dq_o | output | BYTE_W*NUM_BYTES | Read data towards the bus |
| dq_oe_o | output | 1 | Bus drive enable |

## Verification
The bench targets the following corner cases.
- **Read right after a write to the same address.** A design whose write lagged one edge further would return stale data.
- **Per-lane and all-lanes-disabled writes.** A broken lane decode would corrupt the neighbouring byte or write on an abort.
- **Fourth-beat wrap in both burst orders.** A wrong counter or order would walk into the next four-word block or visit beats out of order.
- **A stall inserted between a write command and its data.** A design that did not freeze would store the junk bus value present during the stall.
- **An output-enable pulse inside a clock cycle.** A registered enable would miss the change.

// File: rtl/lw_sram_pkg.sv
package lw_sram_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } op_e;
endpackage

// File: rtl/lw_sram_ctrl.sv
module lw_sram_ctrl
  import lw_sram_pkg::*;
#(
  parameter int NUM_BYTES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic                 load_i,
  input  logic                 selected_i,
  input  logic                 rd_i,
  input  logic [NUM_BYTES-1:0] be_ni,
  output op_e                  op_o,
  output logic [NUM_BYTES-1:0] be_no
);
  op_e                  op_q;
  logic [NUM_BYTES-1:0] be_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q <= OP_IDLE;
      be_q <= '1;
    end else if (en_i) begin
      be_q <= be_ni;
      if (load_i) begin
        if (!selected_i)  op_q <= OP_IDLE;
        else if (rd_i)    op_q <= OP_RD;
        else              op_q <= OP_WR;
      end
    end
  end

  assign op_o  = op_q;
  assign be_no = be_q;

  a_r6_keep_type: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !load_i) |=> (op_q == $past(op_q)));
  a_r11_stall_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> ($stable(op_q) && $stable(be_q)));
  a_r5_desel_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && load_i && !selected_i) |=> (op_q == OP_IDLE));
endmodule

// File: rtl/lw_sram_burst.sv
module lw_sram_burst #(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] start_i,
  input  logic              order_il_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int CNT_W = 2;

  logic [ADDR_W-1:0] base_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  ofs;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else if (en_i) begin
      if (load_i) begin
        base_q <= start_i;
        cnt_q  <= '0;
      end else begin
        cnt_q  <= cnt_q + 1'b1;
      end
    end
  end

  // interleaved: XOR of start and count; linear: sum modulo burst length
  assign ofs    = order_il_i ? (base_q[CNT_W-1:0] ^ cnt_q) : (base_q[CNT_W-1:0] + cnt_q);
  assign addr_o = {base_q[ADDR_W-1:CNT_W], ofs};

  a_r6_cnt_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !load_i) |=> (cnt_q == $past(cnt_q) + 2'd1));
  a_r8_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !load_i && cnt_q == 2'd3) |=> (addr_o == base_q));
  a_r8_upper_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !load_i) |=> (addr_o[ADDR_W-1:CNT_W] == $past(addr_o[ADDR_W-1:CNT_W])));
  a_r11_addr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> ($stable(base_q) && $stable(cnt_q)));
endmodule

// File: rtl/lw_sram_array.sv
module lw_sram_array #(
  parameter int ADDR_W    = 8,
  parameter int BYTE_W    = 9,
  parameter int NUM_BYTES = 2
) (
  input  logic                        clk_i,
  input  logic [NUM_BYTES-1:0]        we_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [BYTE_W*NUM_BYTES-1:0] wdata_i,
  output logic [BYTE_W*NUM_BYTES-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_lane
    logic [BYTE_W-1:0] bank [DEPTH];

    always_ff @(posedge clk_i) begin
      if (we_i[b]) bank[addr_i] <= wdata_i[b*BYTE_W +: BYTE_W];
    end

    assign rdata_o[b*BYTE_W +: BYTE_W] = bank[addr_i];
  end
endmodule

// File: rtl/lw_sram.sv
module lw_sram
  import lw_sram_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int BYTE_W    = 9,
  parameter int NUM_BYTES = 2
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        clk_en_ni,
  input  logic                        sel_a_ni,
  input  logic                        sel_b_i,
  input  logic                        sel_c_ni,
  input  logic                        adv_i,
  input  logic                        rd_nwr_i,
  input  logic [NUM_BYTES-1:0]        byte_wr_ni,
  input  logic                        order_il_i,
  input  logic                        out_en_ni,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [BYTE_W*NUM_BYTES-1:0] dq_i,
  output logic [BYTE_W*NUM_BYTES-1:0] dq_o,
  output logic                        dq_oe_o
);
  logic                 en;
  logic                 load;
  logic                 selected;
  op_e                  op;
  logic [NUM_BYTES-1:0] be_n;
  logic [NUM_BYTES-1:0] we;
  logic [ADDR_W-1:0]    acc_addr;

  assign en       = !clk_en_ni;
  assign load     = !adv_i;
  assign selected = !sel_a_ni && sel_b_i && !sel_c_ni;

  lw_sram_ctrl #(.NUM_BYTES(NUM_BYTES)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en),
    .load_i     (load),
    .selected_i (selected),
    .rd_i       (rd_nwr_i),
    .be_ni      (byte_wr_ni),
    .op_o       (op),
    .be_no      (be_n)
  );

  lw_sram_burst #(.ADDR_W(ADDR_W)) u_burst (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en),
    .load_i     (load),
    .start_i    (addr_i),
    .order_il_i (order_il_i),
    .addr_o     (acc_addr)
  );

  // late write: data for the registered write command lands on the next enabled edge
  assign we = (en && op == OP_WR) ? ~be_n : '0;

  lw_sram_array #(
    .ADDR_W    (ADDR_W),
    .BYTE_W    (BYTE_W),
    .NUM_BYTES (NUM_BYTES)
  ) u_array (
    .clk_i   (clk_i),
    .we_i    (we),
    .addr_i  (acc_addr),
    .wdata_i (dq_i),
    .rdata_o (dq_o)
  );

  assign dq_oe_o = (op == OP_RD) && !out_en_ni;

  a_r12_wr_no_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_WR) |-> !dq_oe_o);
  a_r10_oe_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_en_ni |-> !dq_oe_o);
  a_r9_abort_no_we: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_WR && &be_n) |-> (we == '0));
endmodule

// File: tb/lw_sram_tb.sv
module lw_sram_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int BW = 9;
  localparam int NB = 2;
  localparam int W  = BW * NB;

  logic          clk_i = 0;
  logic          rst_ni;
  logic          clk_en_ni, sel_a_ni, sel_b_i, sel_c_ni, adv_i, rd_nwr_i;
  logic [NB-1:0] byte_wr_ni;
  logic          order_il_i, out_en_ni;
  logic [AW-1:0] addr_i;
  logic [W-1:0]  dq_i, dq_o;
  logic          dq_oe_o;

  lw_sram #(.ADDR_W(AW), .BYTE_W(BW), .NUM_BYTES(NB)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .clk_en_ni(clk_en_ni), .sel_a_ni(sel_a_ni),
    .sel_b_i(sel_b_i), .sel_c_ni(sel_c_ni), .adv_i(adv_i), .rd_nwr_i(rd_nwr_i),
    .byte_wr_ni(byte_wr_ni), .order_il_i(order_il_i), .out_en_ni(out_en_ni),
    .addr_i(addr_i), .dq_i(dq_i), .dq_o(dq_o), .dq_oe_o(dq_oe_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  typedef struct {
    int         cyc;
    bit         drive;
    logic [W-1:0] data;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_checks = 0;
  int   n_fail   = 0;
  int   ncyc     = 0;

  // requirement-level model
  logic [W-1:0]  m_mem [1 << AW];
  logic [AW-1:0] m_base;
  logic [1:0]    m_cnt;
  int            m_op;   // 0 idle, 1 read, 2 write
  logic [NB-1:0] m_be;

  function automatic logic [AW-1:0] m_addr();
    logic [1:0] o;
    o = order_il_i ? (m_base[1:0] ^ m_cnt) : (m_base[1:0] + m_cnt);
    return {m_base[AW-1:2], o};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: compares scoreboard entries due at this negedge
  always @(negedge clk_i) begin
    ncyc++;
    while (exp_q.size() > 0 && exp_q[0].cyc == ncyc) begin
      exp_t e;
      e = exp_q.pop_front();
      n_checks++;
      if (dq_oe_o !== e.drive || (e.drive && dq_o !== e.data)) begin
        n_fail++;
        $display("FAIL %s: actual oe=%0b data=%h expected oe=%0b data=%h",
                 e.tag, dq_oe_o, dq_o, e.drive, e.data);
      end
    end
  end

  task automatic step(input string tag, input bit en_n, input bit a_n, input bit b, input bit c_n,
                      input bit adv, input bit rd, input logic [NB-1:0] be_n,
                      input logic [AW-1:0] a, input logic [W-1:0] d, input bit oe_n);
    exp_t e;
    @(negedge clk_i); #1;
    clk_en_ni = en_n; sel_a_ni = a_n; sel_b_i = b; sel_c_ni = c_n;
    adv_i = adv; rd_nwr_i = rd; byte_wr_ni = be_n; addr_i = a; dq_i = d; out_en_ni = oe_n;
    if (!en_n) begin
      if (m_op == 2) begin
        logic [AW-1:0] wa;
        wa = m_addr();
        for (int k = 0; k < NB; k++)
          if (!m_be[k]) m_mem[wa][k*BW +: BW] = d[k*BW +: BW];
      end
      if (!adv) begin
        m_base = a; m_cnt = 0;
        m_op = (!a_n && b && !c_n) ? (rd ? 1 : 2) : 0;
      end else begin
        m_cnt = m_cnt + 1'b1;
      end
      m_be = be_n;
    end
    e.cyc = ncyc + 1; e.drive = (m_op == 1) && !oe_n; e.data = m_mem[m_addr()]; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic rd(input string tag, input logic [AW-1:0] a, input logic [W-1:0] d, input bit oe_n = 0);
    step(tag, 0, 0, 1, 0, 0, 1, 2'b11, a, d, oe_n);
  endtask
  task automatic wr(input string tag, input logic [AW-1:0] a, input logic [NB-1:0] be, input logic [W-1:0] d);
    step(tag, 0, 0, 1, 0, 0, 0, be, a, d, 0);
  endtask
  // continue: selects inactive, rd_nwr low and junk address must all be ignored
  task automatic cont(input string tag, input logic [NB-1:0] be, input logic [W-1:0] d, input bit oe_n = 0);
    step(tag, 0, 1, 0, 1, 1, 0, be, 8'hc7, d, oe_n);
  endtask
  // stall: inputs would form a selected write load if not frozen
  task automatic stall(input string tag, input logic [W-1:0] d);
    step(tag, 1, 0, 1, 0, 0, 0, 2'b00, 8'h55, d, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_ni = 0; clk_en_ni = 0; sel_a_ni = 1; sel_b_i = 0; sel_c_ni = 1; adv_i = 0; rd_nwr_i = 1;
    byte_wr_ni = 2'b11; order_il_i = 1; out_en_ni = 0; addr_i = '0; dq_i = '0;
    m_base = '0; m_cnt = '0; m_op = 0; m_be = 2'b11;
    for (int i = 0; i < (1 << AW); i++) m_mem[i] = '0;
    repeat (3) @(posedge clk_i);
    #1 chk(dq_oe_o === 1'b0, "R1 reset", {17'd0, dq_oe_o}, '0);
    @(negedge clk_i); rst_ni = 1;
    step("R1", 0, 1, 0, 1, 0, 1, 2'b11, 8'h00, '0, 0);

    // late write, alternation without dead cycles
    wr("R12", 8'h10, 2'b00, '0);
    wr("R12", 8'h11, 2'b00, 18'h2a5c3);
    rd("R4",  8'h10, 18'h13579);
    rd("R3",  8'h11, '0);
    wr("R4",  8'h12, 2'b00, '0);
    rd("R4",  8'h12, 18'h0f0f0);
    rd("R2",  8'h11, '0);
    // partial lane writes
    wr("R12", 8'h11, 2'b10, '0);
    rd("R3",  8'h11, 18'h3ffff);
    wr("R12", 8'h10, 2'b01, '0);
    rd("R3",  8'h10, 18'h1aaaa);
    // write abort
    wr("R9",  8'h12, 2'b11, '0);
    rd("R9",  8'h12, 18'h3c3c3);

    // interleaved burst write from 0x21, read back as burst
    wr("R7",   8'h21, 2'b00, '0);
    cont("R6", 2'b00, 18'h10001);
    cont("R6", 2'b00, 18'h20002);
    cont("R6", 2'b00, 18'h30003);
    rd("R7",   8'h21, 18'h04004);
    cont("R7", 2'b11, '0);
    cont("R7", 2'b11, '0);
    cont("R7", 2'b11, '0);
    cont("R8", 2'b11, '0);
    // per-beat lane enables on a second burst
    wr("R6",   8'h21, 2'b10, '0);
    cont("R6", 2'b11, 18'h15555);
    cont("R6", 2'b01, 18'h26666);
    cont("R6", 2'b00, 18'h37777);
    rd("R6",   8'h21, 18'h08888);
    cont("R6", 2'b11, '0);
    cont("R6", 2'b11, '0);
    cont("R6", 2'b11, '0);

    // linear order
    step("R5", 0, 1, 1, 0, 0, 1, 2'b11, 8'h00, '0, 0);
    order_il_i = 0;
    wr("R8",   8'h32, 2'b00, '0);
    cont("R8", 2'b00, 18'h1b0b0);
    cont("R8", 2'b00, 18'h2c1c1);
    cont("R8", 2'b00, 18'h3d2d2);
    rd("R8",   8'h33, 18'h0e3e3);
    cont("R8", 2'b11, '0);
    cont("R8", 2'b11, '0);
    cont("R8", 2'b11, '0);
    cont("R8", 2'b11, '0);
    rd("R8",   8'h30, '0);
    rd("R8",   8'h32, '0);

    // deselect via each select, then continued deselect
    step("R5", 0, 1, 1, 0, 0, 1, 2'b11, 8'h10, '0, 0);
    step("R5", 0, 0, 0, 0, 0, 1, 2'b11, 8'h10, '0, 0);
    step("R5", 0, 0, 1, 1, 0, 1, 2'b11, 8'h10, '0, 0);
    step("R5", 0, 0, 1, 0, 1, 1, 2'b11, 8'h10, '0, 0);

    // dummy read and asynchronous output enable
    rd("R10",   8'h10, '0, 1);
    cont("R10", 2'b11, '0, 1);
    rd("R10",   8'h10, '0, 0);
    @(posedge clk_i); #1 out_en_ni = 1;
    #1 chk(dq_oe_o === 1'b0, "R10 async off", {17'd0, dq_oe_o}, '0);
    out_en_ni = 0;
    #1 chk(dq_oe_o === 1'b1, "R10 async on", {17'd0, dq_oe_o}, 18'd1);

    // stalls during read burst and between write command and data
    rd("R11",   8'h30, '0);
    stall("R11", '0);
    stall("R11", '0);
    cont("R11", 2'b11, '0);
    wr("R11",   8'h13, 2'b00, '0);
    stall("R11", 18'h3dead);
    stall("R11", 18'h2beef);
    rd("R11",   8'h13, 18'h1c0de);
    rd("R11",   8'h55, '0);
    rd("R11",   8'h13, '0);

    step("R5", 0, 1, 0, 1, 0, 1, 2'b11, 8'h00, '0, 0);
    step("R5", 0, 1, 0, 1, 1, 1, 2'b11, 8'h00, '0, 0);
    repeat (3) @(negedge clk_i);
    if (exp_q.size() != 0) chk(1'b0, "scoreboard drain", exp_q.size(), '0);
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule